// File: doc/BRIEF.md
# Comparator Measurement Sequencer

This block is the digital controller for a single analog comparator channel. It drives the comparator's enable line and waits a programmable number of warm-up cycles after each enable rise. It then samples the one-bit comparator output into a status bit. Software picks one of four behaviours through a 2-bit mode field: off, free-running sampling on every clock, a single sample started by a software write, or a single sample started by a hardware event line.

Each completed sample does three things. It updates the status bit, emits a one-cycle event pulse to neighbouring logic, and sets a sticky flag. The flag drives the interrupt output when its mask bit is set. Software reaches the block over a plain write strobe with address and data, plus an asynchronous read port that decodes an address.

Top module: `cmp_seq_top`

## Requirements
- R1: After reset, cmp_en, evt_out and irq are low, and every register reads zero: mode, trigger enable, delay, start bits, result, flag and mask.
- R2: Register 0 holds the mode in bits [1:0] (0 off, 1 continuous, 2 software single, 3 event single) and the event-trigger enable in bit 2. In mode 0, cmp_en is low no later than the cycle after the mode is seen, and no sample is taken.
- R3: Register 2 holds the warm-up delay D. cmp_en rises in the cycle after a start condition is present. The first sample is taken at the clock edge that ends the (D+1)-th cycle with cmp_en high, and status and evt_out show it in the following cycle.
- R4: In mode 1, after the first sample, a new sample is taken on every clock edge for as long as the mode stays 1. Register 3 reads the latest result in bit 0 and the flag in bit 1.
- R5: In mode 2, a write of 1 to bit 0 of register 1 sets the software start bit (readable in bit 0 of register 1). This yields exactly one sample. Completion clears the bit and drops cmp_en.
- R6: A pulse on periph_evt_in sets the event start bit (readable in bit 1 of register 1), but only when the trigger enable is 1. In mode 3 that bit yields exactly one sample and is cleared on completion.
- R7: A start request that arrives while a request is already pending merges into it. It does not cause a second sample. A request that coincides with completion is dropped.
- R8: Writing mode 0 clears both start bits. It aborts a pending single sample without a status update or event.
- R9: evt_out is high for exactly one cycle per sample, in the cycle in which the new result is first visible.
- R10: Bit 0 written to register 4 sets the mask, and bit 0 written to register 5 clears it. Both registers read the mask. Bit 0 written to register 6 clears the flag. A sample that completes in the same cycle wins over the clear. irq equals flag AND mask and stays high until the flag is cleared.
- R11: A software start written in mode 0, and an event arriving while the trigger enable is 0, leave both start bits at 0 and cause no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| periph_evt_in | input | 1 | Hardware trigger pulse |
| cmp_result | input | 1 | Comparator output to sample |
| cmp_en | output | 1 | Comparator enable |
| evt_out | output | 1 | One-cycle pulse per completed sample |
| irq | output | 1 | Masked interrupt request |

## Verification
The comparator input changes at random every cycle. A continuous run at a short delay therefore shows whether each clock edge really takes a fresh sample, and a run at delays 0 and 255 exposes off-by-one errors in the warm-up count. Single-sample runs repeat the start request while one is pending, which separates merging from queuing. An abort in the middle of warm-up separates a clean cancel from a stray status update. Events are sent with the trigger enable at 0 and at 1, and starts are written in mode 0, to show that gated requests leave the start bits untouched. Flag clears are issued during continuous sampling to exercise the rule that a completing sample wins over the clear.

// File: rtl/cmp_seq_pkg.sv
package cmp_seq_pkg;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_CONT = 2'd1,
      MODE_USER = 2'd2,
      MODE_EVT  = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WARM = 2'd1,
      PH_RUN  = 2'd2
   } phase_e;

   localparam int unsigned A_CFG   = 0;
   localparam int unsigned A_START = 1;
   localparam int unsigned A_DELAY = 2;
   localparam int unsigned A_STAT  = 3;
   localparam int unsigned A_MSET  = 4;
   localparam int unsigned A_MCLR  = 5;
   localparam int unsigned A_FCLR  = 6;

   localparam int unsigned MIN_ADDR_W = 3;

endpackage

// File: rtl/cmp_seq_regs.sv
module cmp_seq_regs
   import cmp_seq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DLY_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_i,
   input  logic              start_wr_i,
   input  logic              dly_wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              periph_evt_i,
   input  logic              done_i,
   output mode_e             mode_o,
   output logic              trig_en_o,
   output logic [DLY_W-1:0]  dly_o,
   output logic              ustart_o,
   output logic              estart_o
);

   mode_e             mode_q;
   logic              trig_en_q;
   logic [DLY_W-1:0]  dly_q;
   logic              ustart_q, estart_q;
   logic              ustart_d, estart_d;
   logic              off_wr;

   assign off_wr = cfg_wr_i && (wr_data_i[1:0] == 2'd0);

   // Start bits: set by request, cleared on completion of their own
   // sample; clear wins over a coincident set, mode-0 write wins over all.
   always_comb begin
      ustart_d = ustart_q;
      estart_d = estart_q;
      if (start_wr_i && wr_data_i[0] && (mode_q != MODE_OFF))
         ustart_d = 1'b1;
      if (periph_evt_i && trig_en_q)
         estart_d = 1'b1;
      if (done_i && (mode_q == MODE_USER))
         ustart_d = 1'b0;
      if (done_i && (mode_q == MODE_EVT))
         estart_d = 1'b0;
      if (off_wr) begin
         ustart_d = 1'b0;
         estart_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_OFF;
         trig_en_q <= 1'b0;
         dly_q     <= '0;
         ustart_q  <= 1'b0;
         estart_q  <= 1'b0;
      end else begin
         if (cfg_wr_i) begin
            mode_q    <= mode_e'(wr_data_i[1:0]);
            trig_en_q <= wr_data_i[2];
         end
         if (dly_wr_i)
            dly_q <= wr_data_i[DLY_W-1:0];
         ustart_q <= ustart_d;
         estart_q <= estart_d;
      end
   end

   assign mode_o    = mode_q;
   assign trig_en_o = trig_en_q;
   assign dly_o     = dly_q;
   assign ustart_o  = ustart_q;
   assign estart_o  = estart_q;

endmodule

// File: rtl/cmp_seq_timer.sv
module cmp_seq_timer
   import cmp_seq_pkg::*;
#(
   parameter int unsigned DLY_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  mode_e            mode_i,
   input  logic             ustart_i,
   input  logic             estart_i,
   input  logic [DLY_W-1:0] dly_i,
   input  logic             cmp_result_i,
   output logic             cmp_en_o,
   output logic             done_o,
   output logic             result_o
);

   phase_e            phase_q, phase_d;
   logic [DLY_W-1:0]  cnt_q, cnt_d;
   logic              result_q;
   logic              need;

   always_comb begin
      unique case (mode_i)
         MODE_CONT: need = 1'b1;
         MODE_USER: need = ustart_i;
         MODE_EVT:  need = estart_i;
         default:   need = 1'b0;
      endcase
   end

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      done_o  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (need) begin
               phase_d = PH_WARM;
               cnt_d   = dly_i;
            end
         end
         PH_WARM: begin
            if (!need) begin
               phase_d = PH_IDLE;
            end else if (cnt_q == '0) begin
               done_o  = 1'b1;
               phase_d = (mode_i == MODE_CONT) ? PH_RUN : PH_IDLE;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         PH_RUN: begin
            if (mode_i != MODE_CONT)
               phase_d = PH_IDLE;
            else
               done_o = 1'b1;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cnt_q    <= '0;
         result_q <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         if (done_o)
            result_q <= cmp_result_i;
      end
   end

   assign cmp_en_o = (phase_q != PH_IDLE);
   assign result_o = result_q;

endmodule

// File: rtl/cmp_seq_irq.sv
module cmp_seq_irq #(
   parameter bit IRQ_REG = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   input  logic mask_set_i,
   input  logic mask_clr_i,
   input  logic flag_clr_i,
   output logic evt_o,
   output logic flag_o,
   output logic mask_o,
   output logic irq_o
);

   logic flag_q, mask_q, evt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         mask_q <= 1'b0;
         evt_q  <= 1'b0;
      end else begin
         evt_q <= done_i;
         if (done_i)
            flag_q <= 1'b1;
         else if (flag_clr_i)
            flag_q <= 1'b0;
         if (mask_set_i)
            mask_q <= 1'b1;
         else if (mask_clr_i)
            mask_q <= 1'b0;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag_q & mask_q;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = flag_q & mask_q;
      end
   endgenerate

   assign evt_o  = evt_q;
   assign flag_o = flag_q;
   assign mask_o = mask_q;

endmodule

// File: rtl/cmp_seq_top.sv
module cmp_seq_top
   import cmp_seq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DLY_W   = 8,
   parameter bit          IRQ_REG = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              periph_evt_in,
   input  logic              cmp_result,
   output logic              cmp_en,
   output logic              evt_out,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] AD_CFG   = ADDR_W'(A_CFG);
   localparam logic [ADDR_W-1:0] AD_START = ADDR_W'(A_START);
   localparam logic [ADDR_W-1:0] AD_DELAY = ADDR_W'(A_DELAY);
   localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(A_STAT);
   localparam logic [ADDR_W-1:0] AD_MSET  = ADDR_W'(A_MSET);
   localparam logic [ADDR_W-1:0] AD_MCLR  = ADDR_W'(A_MCLR);
   localparam logic [ADDR_W-1:0] AD_FCLR  = ADDR_W'(A_FCLR);

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("cmp_seq_top: ADDR_W too small for register map");
      end
      if (DLY_W < 1 || DLY_W > DATA_W) begin : g_bad_dly
         $error("cmp_seq_top: DLY_W must be 1..DATA_W");
      end
      if (DATA_W < 3) begin : g_bad_data
         $error("cmp_seq_top: DATA_W must hold the config field");
      end
   endgenerate

   logic             cfg_wr, start_wr, dly_wr;
   logic             mask_set_stb, mask_clr_stb, flag_clr_stb;
   mode_e            mode_q;
   logic             trig_en_q, ustart_q, estart_q;
   logic [DLY_W-1:0] dly_q;
   logic             done, result_q, flag_q, mask_q;

   assign cfg_wr       = wr_en && (wr_addr == AD_CFG);
   assign start_wr     = wr_en && (wr_addr == AD_START);
   assign dly_wr       = wr_en && (wr_addr == AD_DELAY);
   assign mask_set_stb = wr_en && (wr_addr == AD_MSET) && wr_data[0];
   assign mask_clr_stb = wr_en && (wr_addr == AD_MCLR) && wr_data[0];
   assign flag_clr_stb = wr_en && (wr_addr == AD_FCLR) && wr_data[0];

   cmp_seq_regs #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr_i     (cfg_wr),
      .start_wr_i   (start_wr),
      .dly_wr_i     (dly_wr),
      .wr_data_i    (wr_data),
      .periph_evt_i (periph_evt_in),
      .done_i       (done),
      .mode_o       (mode_q),
      .trig_en_o    (trig_en_q),
      .dly_o        (dly_q),
      .ustart_o     (ustart_q),
      .estart_o     (estart_q)
   );

   cmp_seq_timer #(.DLY_W(DLY_W)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (mode_q),
      .ustart_i     (ustart_q),
      .estart_i     (estart_q),
      .dly_i        (dly_q),
      .cmp_result_i (cmp_result),
      .cmp_en_o     (cmp_en),
      .done_o       (done),
      .result_o     (result_q)
   );

   cmp_seq_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (done),
      .mask_set_i (mask_set_stb),
      .mask_clr_i (mask_clr_stb),
      .flag_clr_i (flag_clr_stb),
      .evt_o      (evt_out),
      .flag_o     (flag_q),
      .mask_o     (mask_q),
      .irq_o      (irq)
   );

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         AD_CFG:          rd_data = DATA_W'({trig_en_q, mode_q});
         AD_START:        rd_data = DATA_W'({estart_q, ustart_q});
         AD_DELAY:        rd_data = DATA_W'(dly_q);
         AD_STAT:         rd_data = DATA_W'({flag_q, result_q});
         AD_MSET, AD_MCLR: rd_data = DATA_W'(mask_q);
         default:         rd_data = '0;
      endcase
   end

endmodule

// File: rtl/cmp_seq_chk.sv
module cmp_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_q,
   input logic       ustart_q,
   input logic       estart_q,
   input logic       flag_q,
   input logic       flag_clr_stb,
   input logic       cmp_en,
   input logic       evt_out,
   input logic       irq
);

   p_off_idles_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd0) |=> !cmp_en);

   p_evt_after_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_out |-> $past(cmp_en));

   p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_q || $past(flag_q)));

   p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr_stb) |=> flag_q);

   p_ustart_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ustart_q) |-> (evt_out || mode_q == 2'd0));

   p_estart_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(estart_q) |-> (evt_out || mode_q == 2'd0));

endmodule

bind cmp_seq_top cmp_seq_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_q       (mode_q),
   .ustart_q     (ustart_q),
   .estart_q     (estart_q),
   .flag_q       (flag_q),
   .flag_clr_stb (flag_clr_stb),
   .cmp_en       (cmp_en),
   .evt_out      (evt_out),
   .irq          (irq)
);

// File: tb/tb_cmp_seq_top.sv
`timescale 1ns/1ps
module tb_cmp_seq_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       periph_evt_in = 1'b0;
   logic       cmp_result = 1'b0;
   logic       cmp_en, evt_out, irq;

   always #2 clk = ~clk;

   cmp_seq_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .periph_evt_in(periph_evt_in), .cmp_result(cmp_result),
      .cmp_en(cmp_en), .evt_out(evt_out), .irq(irq)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    evt_seen = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_mode, m_ten, m_dly, m_us, m_es, m_mask, m_flag, m_res, m_evt, m_ph, m_cnt;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int model_rd(input int a);
      case (a)
         0: return m_ten * 4 + m_mode;
         1: return m_es * 2 + m_us;
         2: return m_dly;
         3: return m_flag * 2 + m_res;
         4, 5: return m_mask;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_ten = 0; m_dly = 0; m_us = 0; m_es = 0;
         m_mask = 0; m_flag = 0; m_res = 0; m_evt = 0; m_ph = 0; m_cnt = 0;
      end else begin
         int om, ot, ou, oe, need, done;
         om = m_mode; ot = m_ten; ou = m_us; oe = m_es;
         need = (om == 1) || (om == 2 && ou == 1) || (om == 3 && oe == 1);
         done = 0;
         if (m_ph == 0) begin
            if (need) begin m_ph = 1; m_cnt = m_dly; end
         end else if (m_ph == 1) begin
            if (!need) m_ph = 0;
            else if (m_cnt == 0) begin
               done = 1; m_res = cmp_result;
               m_ph = (om == 1) ? 2 : 0;
            end else m_cnt = m_cnt - 1;
         end else begin
            if (om != 1) m_ph = 0;
            else begin done = 1; m_res = cmp_result; end
         end
         if (wr_en) begin
            case (wr_addr)
               0: begin m_mode = wr_data[1:0]; m_ten = wr_data[2]; end
               1: if (wr_data[0] && om != 0) m_us = 1;
               2: m_dly = wr_data;
               4: if (wr_data[0]) m_mask = 1;
               5: if (wr_data[0]) m_mask = 0;
               6: if (wr_data[0]) m_flag = 0;
               default: ;
            endcase
         end
         if (periph_evt_in && ot == 1) m_es = 1;
         if (done && om == 2) m_us = 0;
         if (done && om == 3) m_es = 0;
         if (wr_en && wr_addr == 0 && wr_data[1:0] == 0) begin m_us = 0; m_es = 0; end
         if (done) m_flag = 1;
         m_evt = done;
      end
   end

   // random comparator output and rotating read address
   always @(negedge clk) begin
      cmp_result <= 1'($urandom_range(0, 1));
      rd_addr    <= rd_addr + 3'd1;
   end

   // compare every cycle, after the negedge drives settle
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         chk("R3", "cmp_en", int'(cmp_en), int'(m_ph != 0));
         chk("R9", "evt_out", int'(evt_out), m_evt);
         chk("R10", "irq", int'(irq), m_flag & m_mask);
         chk(cur_req, $sformatf("rd_data[%0d]", rd_addr), int'(rd_data), model_rd(int'(rd_addr)));
         if (evt_out) evt_seen++;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_evt();
      @(negedge clk);
      periph_evt_in = 1'b1;
      @(negedge clk);
      periph_evt_in = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int base;
      idle(5);
      #1;
      chk("R1", "cmp_en in reset", int'(cmp_en), 0);
      chk("R1", "evt_out in reset", int'(evt_out), 0);
      chk("R1", "irq in reset", int'(irq), 0);
      rst_n = 1'b1;
      idle(10);

      cur_req = "R2";
      idle(10);
      chk("R2", "cmp_en while off", int'(cmp_en), 0);

      cur_req = "R11";
      base = evt_seen;
      wr(1, 1);
      wr(0, 3);
      pulse_evt();
      idle(12);
      chk("R11", "samples from gated starts", evt_seen - base, 0);
      wr(0, 0);

      cur_req = "R4";
      wr(2, 3);
      wr(0, 1);
      idle(30);
      cur_req = "R10";
      wr(4, 1);
      wr(6, 1);
      idle(4);
      chk("R10", "irq held while sampling", int'(irq), 1);
      wr(0, 0);
      idle(4);
      wr(6, 1);
      idle(2);
      chk("R10", "irq after flag clear", int'(irq), 0);
      wr(5, 1);

      cur_req = "R5";
      wr(2, 5);
      wr(0, 2);
      base = evt_seen;
      wr(1, 1);
      idle(3);
      cur_req = "R7";
      wr(1, 1);
      idle(20);
      chk("R7", "samples for merged user start", evt_seen - base, 1);
      chk("R5", "cmp_en after single", int'(cmp_en), 0);

      cur_req = "R6";
      wr(0, 3);
      base = evt_seen;
      pulse_evt();
      idle(15);
      chk("R6", "samples with trigger disabled", evt_seen - base, 0);
      wr(0, 7);
      pulse_evt();
      idle(3);
      pulse_evt();
      idle(20);
      chk("R6", "samples for merged event", evt_seen - base, 1);

      cur_req = "R8";
      wr(2, 20);
      wr(0, 2);
      base = evt_seen;
      wr(1, 1);
      idle(5);
      wr(0, 0);
      idle(30);
      chk("R8", "samples after abort", evt_seen - base, 0);

      cur_req = "R3";
      wr(2, 0);
      wr(0, 2);
      base = evt_seen;
      wr(1, 1);
      idle(6);
      chk("R3", "samples at zero delay", evt_seen - base, 1);
      wr(2, 255);
      wr(0, 1);
      idle(300);
      wr(0, 0);
      idle(5);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule